// File: doc/BRIEF.md
# Program Interruption Code Encoder

This block sits between the execution unit's exception detectors and the logic that saves the old program status. When an instruction finishes with one or more exception flags raised, the execution unit pulses a strobe. Each flag arrives with its own 7-bit coded value.

On the strobe, the block does the following:
- It drops the two maskable overflow conditions when the program mask disables them. The mask is read from the field that belongs to the current addressing mode.
- It checks a monitor call against a 16-bit monitor-class mask register.
- It picks a single coded condition and merges a concurrent PER event into the upper bit of the code.

One cycle later it presents the 16-bit interruption code, the instruction-length code (both as a bare 2-bit value and as a byte aligned for the extended-mode save area) and the monitor class field. A request line accompanies these outputs for exactly that one cycle. A condition that is masked off is thrown away, not held.

The monitor masks are a small register inside the block. It is cleared by reset and loaded through a write strobe.

Top module: `pic_encoder`

## Requirements
- R1: Reset clears all outputs to zero and clears all 16 monitor-class mask bits, so a monitor call issued after reset, with no mask load, raises no request.
- R2: One cycle after a strobe with a single live coded condition of value c, `irq` is 1 and `int_code` = {9'b0, c}. Code bits 15:8 are always zero. `irq` returns to 0 in the next cycle unless another strobe arrives.
- R3: When several live coded conditions arrive together, the one with the numerically lowest coded value is reported. The monitor event takes part in this choice with code 7'h40.
- R4: A PER event with no live coded condition gives `int_code` = 16'h0080.
- R5: A PER event together with a live coded condition c gives `int_code` = 16'h0080 | c.
- R6: The fixed-point overflow flag (index FXO_IDX) is live only when the enable bit is 1. In extended mode (`ec_mode`=1) that bit is `pmask_ec[3]`; in basic mode it is `pmask_bc[3]`.
- R7: The decimal overflow flag (index DCO_IDX) is live only when `pmask_ec[2]` (extended mode) or `pmask_bc[2]` (basic mode) is 1.
- R8: A condition dropped by its mask is not held pending: a later strobe with no flags raises no request.
- R9: A monitor call of class k is live when `mmask_q` bit (15-k) is 1; bit 15 holds class 0. The monitor event has code 7'h40, forces ILC 2, and, when it is the reported condition, drives `mon_class_out` = {12'b0, k}. Exception codes never use 7'h40.
- R10: A monitor call whose class mask bit is 0 raises no request.
- R11: When the monitor event is not reported, `ilc` equals `instr_ilc`. `ilc_byte` is {5'b0, ilc, 1'b0} in extended mode and 8'h00 in basic mode.
- R12: Without a strobe the flags are ignored: `irq` is 0 and `int_code`, `ilc`, `ilc_byte` and `mon_class_out` are all zero.
- R13: A masked-off condition never wins the priority choice, even when its code is the lowest present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| exc_stb | input | 1 | End-of-instruction exception strobe |
| exc_flag | input | NUM_EXC | Exception flags, one per detector |
| exc_code | input | NUM_EXC*7 | Coded value per flag; flag i uses bits 7i+6:7i |
| per_event | input | 1 | PER event raised with this strobe |
| mon_call | input | 1 | Monitor call executed |
| mon_class | input | 4 | Monitor class of the call |
| ec_mode | input | 1 | 1 = extended mode, 0 = basic mode |
| pmask_ec | input | 4 | Program mask field used in extended mode |
| pmask_bc | input | 4 | Program mask field used in basic mode |
| instr_ilc | input | 2 | Length code of the instruction |
| mmask_we | input | 1 | Load strobe for the monitor mask register |
| mmask_din | input | 16 | New monitor masks, bit 15 = class 0 |
| irq | output | 1 | Program interruption request |
| int_code | output | 16 | Interruption code |
| ilc | output | 2 | Instruction-length code |
| ilc_byte | output | 8 | ILC placed in bits 2:1 of the byte, extended mode only |
| mon_class_out | output | 16 | Monitor class field, high byte zero |

## Verification
The bench targets the point where masking and priority meet. In that case a masked fixed-point overflow carries the lowest code present. A design that applied the mask after the priority choice would then report nothing, or report the masked code. Mode selection is tested by giving the two mask fields opposite values, so a design that read the wrong field would raise or drop the overflow incorrectly. The monitor class mask bit order is tested by enabling one class and calling its neighbour, which would catch a reversed mapping. The bench also checks that a monitor call beaten by a lower code leaves the class field and the ILC forcing unused, and that a discarded condition leaves nothing pending for the next strobe.

// File: rtl/pic_pkg.sv
package pic_pkg;
  localparam int CODE_W  = 7;
  localparam int INT_W   = 16;
  localparam int ILC_W   = 2;
  localparam int MCLS_W  = 16;
  localparam logic [CODE_W-1:0] MON_CODE = 7'h40;
  localparam logic [ILC_W-1:0]  MON_ILC  = 2'd2;

  function automatic logic [7:0] ilc_to_byte(input logic [ILC_W-1:0] l);
    return {5'b0, l, 1'b0};
  endfunction
endpackage

// File: rtl/pic_mon_mask.sv
module pic_mon_mask #(
  parameter int CLASSES = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               we,
  input  logic [CLASSES-1:0] din,
  output logic [CLASSES-1:0] mask_q
);
  always_ff @(posedge clk) begin
    if (rst)     mask_q <= '0;
    else if (we) mask_q <= din;
  end
endmodule

// File: rtl/pic_mask.sv
module pic_mask #(
  parameter int NUM_EXC = 8,
  parameter int FXO_IDX = 2,
  parameter int DCO_IDX = 3,
  parameter int CLASSES = 16,
  localparam int CLASS_W = $clog2(CLASSES)
) (
  input  logic [NUM_EXC-1:0] exc_flag,
  input  logic               ec_mode,
  input  logic [3:0]         pmask_ec,
  input  logic [3:0]         pmask_bc,
  input  logic               mon_call,
  input  logic [CLASS_W-1:0] mon_class,
  input  logic [CLASSES-1:0] mon_mask,
  output logic [NUM_EXC-1:0] live,
  output logic               mon_live
);
  logic [3:0]         pm;
  logic [CLASSES-1:0] by_class;

  assign pm = ec_mode ? pmask_ec : pmask_bc;

  for (genvar i = 0; i < NUM_EXC; i++) begin : g_live
    if (i == FXO_IDX) begin : g_fxo
      assign live[i] = exc_flag[i] & pm[3];
    end else if (i == DCO_IDX) begin : g_dco
      assign live[i] = exc_flag[i] & pm[2];
    end else begin : g_plain
      assign live[i] = exc_flag[i];
    end
  end

  // class 0 sits in the most significant mask bit
  for (genvar k = 0; k < CLASSES; k++) begin : g_cls
    assign by_class[k] = mon_mask[CLASSES-1-k];
  end

  assign mon_live = mon_call & by_class[mon_class];
endmodule

// File: rtl/pic_pick.sv
module pic_pick
  import pic_pkg::*;
#(
  parameter int NUM_EXC = 8
) (
  input  logic [NUM_EXC-1:0]        live,
  input  logic [NUM_EXC*CODE_W-1:0] codes,
  input  logic                      mon_live,
  output logic                      any,
  output logic [CODE_W-1:0]         best,
  output logic                      best_is_mon
);
  always_comb begin
    any         = mon_live;
    best        = mon_live ? MON_CODE : '1;
    best_is_mon = mon_live;
    for (int i = 0; i < NUM_EXC; i++) begin
      if (live[i] && (!any || codes[i*CODE_W +: CODE_W] < best)) begin
        best        = codes[i*CODE_W +: CODE_W];
        best_is_mon = 1'b0;
        any         = 1'b1;
      end
    end
  end
endmodule

// File: rtl/pic_encoder.sv
module pic_encoder
  import pic_pkg::*;
#(
  parameter int NUM_EXC = 8,
  parameter int FXO_IDX = 2,
  parameter int DCO_IDX = 3,
  parameter int CLASSES = 16,
  localparam int CLASS_W = $clog2(CLASSES)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      exc_stb,
  input  logic [NUM_EXC-1:0]        exc_flag,
  input  logic [NUM_EXC*CODE_W-1:0] exc_code,
  input  logic                      per_event,
  input  logic                      mon_call,
  input  logic [CLASS_W-1:0]        mon_class,
  input  logic                      ec_mode,
  input  logic [3:0]                pmask_ec,
  input  logic [3:0]                pmask_bc,
  input  logic [ILC_W-1:0]          instr_ilc,
  input  logic                      mmask_we,
  input  logic [CLASSES-1:0]        mmask_din,
  output logic                      irq,
  output logic [INT_W-1:0]          int_code,
  output logic [ILC_W-1:0]          ilc,
  output logic [7:0]                ilc_byte,
  output logic [MCLS_W-1:0]         mon_class_out
);
  logic [CLASSES-1:0] mmask_q;
  logic [NUM_EXC-1:0] live;
  logic               mon_live, any, best_is_mon;
  logic [CODE_W-1:0]  best;
  logic               fire, mon_win;
  logic [ILC_W-1:0]   ilc_sel;

  pic_mon_mask #(.CLASSES(CLASSES)) u_mmask (
    .clk(clk), .rst(rst), .we(mmask_we), .din(mmask_din), .mask_q(mmask_q)
  );

  pic_mask #(.NUM_EXC(NUM_EXC), .FXO_IDX(FXO_IDX), .DCO_IDX(DCO_IDX),
             .CLASSES(CLASSES)) u_mask (
    .exc_flag(exc_flag), .ec_mode(ec_mode), .pmask_ec(pmask_ec),
    .pmask_bc(pmask_bc), .mon_call(mon_call), .mon_class(mon_class),
    .mon_mask(mmask_q), .live(live), .mon_live(mon_live)
  );

  pic_pick #(.NUM_EXC(NUM_EXC)) u_pick (
    .live(live), .codes(exc_code), .mon_live(mon_live),
    .any(any), .best(best), .best_is_mon(best_is_mon)
  );

  assign fire    = exc_stb & (any | per_event);
  assign mon_win = any & best_is_mon;
  assign ilc_sel = mon_win ? MON_ILC : instr_ilc;

  always_ff @(posedge clk) begin
    if (rst || !fire) begin
      irq           <= 1'b0;
      int_code      <= '0;
      ilc           <= '0;
      ilc_byte      <= '0;
      mon_class_out <= '0;
    end else begin
      irq           <= 1'b1;
      int_code      <= {8'h00, per_event, (any ? best : {CODE_W{1'b0}})};
      ilc           <= ilc_sel;
      ilc_byte      <= ec_mode ? ilc_to_byte(ilc_sel) : 8'h00;
      mon_class_out <= mon_win ? {{(MCLS_W-CLASS_W){1'b0}}, mon_class} : '0;
    end
  end
endmodule

module pic_encoder_chk
  import pic_pkg::*;
(
  input logic               clk,
  input logic               rst,
  input logic               exc_stb,
  input logic               ec_mode,
  input logic               irq,
  input logic [INT_W-1:0]   int_code,
  input logic [ILC_W-1:0]   ilc,
  input logic [7:0]         ilc_byte,
  input logic [MCLS_W-1:0]  mon_class_out
);
  assert_irq_after_strobe_R2: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(exc_stb));
  assert_upper_zero_R2: assert property (@(posedge clk) disable iff (rst)
    int_code[15:8] == 8'h00);
  assert_quiet_R12: assert property (@(posedge clk) disable iff (rst)
    !irq |-> (int_code == '0 && ilc == '0 && ilc_byte == 8'h00 && mon_class_out == '0));
  assert_mon_ilc_R9: assert property (@(posedge clk) disable iff (rst)
    (irq && int_code[6:0] == MON_CODE) |-> ilc == MON_ILC);
  assert_mon_field_R9: assert property (@(posedge clk) disable iff (rst)
    (mon_class_out != '0) |-> int_code[6:0] == MON_CODE);
  assert_ilc_byte_R11: assert property (@(posedge clk) disable iff (rst)
    (irq && !$past(ec_mode)) |-> ilc_byte == 8'h00);
endmodule

bind pic_encoder pic_encoder_chk u_chk (
  .clk(clk), .rst(rst), .exc_stb(exc_stb), .ec_mode(ec_mode), .irq(irq),
  .int_code(int_code), .ilc(ilc), .ilc_byte(ilc_byte),
  .mon_class_out(mon_class_out)
);

// File: tb/pic_encoder_test.sv
module pic_encoder_test;
  localparam int N = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        exc_stb = 1'b0;
  logic [N-1:0] exc_flag = '0;
  logic [N*7-1:0] exc_code;
  logic        per_event = 1'b0;
  logic        mon_call = 1'b0;
  logic [3:0]  mon_class = '0;
  logic        ec_mode = 1'b1;
  logic [3:0]  pmask_ec = 4'hF;
  logic [3:0]  pmask_bc = 4'hF;
  logic [1:0]  instr_ilc = 2'd1;
  logic        mmask_we = 1'b0;
  logic [15:0] mmask_din = '0;
  logic        irq;
  logic [15:0] int_code;
  logic [1:0]  ilc;
  logic [7:0]  ilc_byte;
  logic [15:0] mon_class_out;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  // per-flag coded values; index 2 = fixed-point overflow, 3 = decimal overflow
  assign exc_code = {7'h11, 7'h0B, 7'h07, 7'h05, 7'h0A, 7'h08, 7'h06, 7'h01};

  always #5 clk = ~clk;

  pic_encoder uut (
    .clk(clk), .rst(rst), .exc_stb(exc_stb), .exc_flag(exc_flag),
    .exc_code(exc_code), .per_event(per_event), .mon_call(mon_call),
    .mon_class(mon_class), .ec_mode(ec_mode), .pmask_ec(pmask_ec),
    .pmask_bc(pmask_bc), .instr_ilc(instr_ilc), .mmask_we(mmask_we),
    .mmask_din(mmask_din), .irq(irq), .int_code(int_code), .ilc(ilc),
    .ilc_byte(ilc_byte), .mon_class_out(mon_class_out)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive one strobe; outputs are valid at the negedge that follows
  task automatic shot(input logic [N-1:0] f, input logic per, input logic mc,
                      input logic [3:0] cls, input logic stb = 1'b1);
    @(negedge clk);
    exc_flag = f; per_event = per; mon_call = mc; mon_class = cls; exc_stb = stb;
    @(negedge clk);
    exc_flag = '0; per_event = 1'b0; mon_call = 1'b0; exc_stb = 1'b0;
  endtask

  task automatic load_mmask(input logic [15:0] v);
    @(negedge clk); mmask_we = 1'b1; mmask_din = v;
    @(negedge clk); mmask_we = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 irq", 32'(irq), 0);
    chk("R1 code", 32'(int_code), 0);
    chk("R1 ilc_byte", 32'(ilc_byte), 0);
    shot('0, 0, 1, 4'd3);
    chk("R1 masks clear", 32'(irq), 0);
  endtask

  task automatic t_single;
    ec_mode = 1; instr_ilc = 2'd1;
    shot(8'b0000_0001, 0, 0, 0);
    chk("R2 irq", 32'(irq), 1);
    chk("R2 code", 32'(int_code), 32'h0001);
    chk("R11 ilc", 32'(ilc), 1);
    chk("R11 ilc_byte ec", 32'(ilc_byte), 32'h02);
    @(negedge clk);
    chk("R2 pulse", 32'(irq), 0);
  endtask

  task automatic t_multi;
    shot(8'b1011_0000, 0, 0, 0);
    chk("R3 lowest", 32'(int_code), 32'h0005);
  endtask

  task automatic t_per;
    ec_mode = 0; instr_ilc = 2'd3;
    shot('0, 1, 0, 0);
    chk("R4 per alone", 32'(int_code), 32'h0080);
    chk("R11 ilc bc", 32'(ilc), 3);
    chk("R11 ilc_byte bc", 32'(ilc_byte), 0);
    ec_mode = 1;
    shot(8'b0100_0000, 1, 0, 0);
    chk("R5 per merged", 32'(int_code), 32'h008B);
  endtask

  task automatic t_fxo;
    ec_mode = 1; pmask_ec = 4'b0111; pmask_bc = 4'b1000;
    shot(8'b0000_0100, 0, 0, 0);
    chk("R6 ec masked", 32'(irq), 0);
    pmask_ec = 4'b1000; pmask_bc = 4'b0000;
    shot(8'b0000_0100, 0, 0, 0);
    chk("R6 ec enabled", 32'(int_code), 32'h0008);
    ec_mode = 0; pmask_ec = 4'b0000; pmask_bc = 4'b1000;
    shot(8'b0000_0100, 0, 0, 0);
    chk("R6 bc enabled", 32'(int_code), 32'h0008);
    pmask_ec = 4'hF; pmask_bc = 4'hF; ec_mode = 1;
  endtask

  task automatic t_dco;
    pmask_ec = 4'b1011;
    shot(8'b0000_1000, 0, 0, 0);
    chk("R7 ec masked", 32'(irq), 0);
    shot('0, 0, 0, 0);
    chk("R8 not pending", 32'(irq), 0);
    pmask_ec = 4'b0100;
    shot(8'b0000_1000, 0, 0, 0);
    chk("R7 ec enabled", 32'(int_code), 32'h000A);
    ec_mode = 0; pmask_ec = 4'hF; pmask_bc = 4'b1011;
    shot(8'b0000_1000, 0, 0, 0);
    chk("R7 bc masked", 32'(irq), 0);
    pmask_bc = 4'hF; ec_mode = 1;
  endtask

  task automatic t_monitor;
    instr_ilc = 2'd1;
    load_mmask(16'h0400);  // class 5 only
    shot('0, 0, 1, 4'd5);
    chk("R9 code", 32'(int_code), 32'h0040);
    chk("R9 ilc", 32'(ilc), 2);
    chk("R9 class", 32'(mon_class_out), 32'h0005);
    shot('0, 0, 1, 4'd4);
    chk("R10 masked class", 32'(irq), 0);
    shot(8'b0000_0001, 0, 1, 4'd5);
    chk("R3 beats monitor", 32'(int_code), 32'h0001);
    chk("R9 ilc not forced", 32'(ilc), 1);
    chk("R9 no class", 32'(mon_class_out), 0);
    shot('0, 1, 1, 4'd5);
    chk("R5 per+monitor", 32'(int_code), 32'h00C0);
  endtask

  task automatic t_masked_low;
    pmask_ec = 4'b0000;
    shot(8'b1000_0100, 0, 0, 0);
    chk("R13 masked loses", 32'(int_code), 32'h0011);
    pmask_ec = 4'hF;
  endtask

  task automatic t_nostb;
    shot(8'b1111_1111, 1, 1, 4'd5, 1'b0);
    chk("R12 irq", 32'(irq), 0);
    chk("R12 code", 32'(int_code), 0);
  endtask

  task automatic t_reset_masks;
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    shot('0, 0, 1, 4'd5);
    chk("R1 masks cleared", 32'(irq), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset();
    t_single();
    t_multi();
    t_per();
    t_fxo();
    t_dco();
    t_monitor();
    t_masked_low();
    t_nostb();
    t_reset_masks();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule